// File: doc/BRIEF.md
# Bridge Short-Circuit Fault Detector

This block watches the digital comparator flags of a power stage with two half-bridge outputs and sorts short circuits and thermal trips into fault classes. Each output supplies its high-side and low-side gate-on state. It also supplies two current comparator flags: one for the regulation limit and one for the short-circuit threshold. A single over-temperature flag covers the whole stage. The comparator flags arrive without a clock relationship, so a two-flop synchronizer sits in front of all timing logic. The gate-on states are taken as already synchronous to the block clock.

A short to ground is declared when a high-side switch is on and its short-threshold flag stays high for a filter time. A short to supply is recognised differently. When low-side current crosses the regulation limit, the block drops its limit-enable output for a blanking window. If the short threshold is reached inside that window, a short is declared. Otherwise limiting resumes. Every detection and every over-temperature onset raises a shutdown request at once. That request holds until the fault manager pulses a clear.

Reporting is held back for a coincidence window. High-side and low-side detections that land inside one window are reported as a single short-across-load pulse. All durations are parameters counted in clock cycles. Every output is a plain control level or a one-cycle pulse. The block has no flow control, because it cannot stall the hazards it reports.

Top module: `bridge_fault_detector`

## Requirements
- R1: After reset, shutdown_o is 0, every bit of lim_en_o is 1 and no event pulse is high.
- R2: A short to ground is detected on output i when hs_on_i[i] is 1 and the synchronized cur_sc_i[i] is high for FILT_CYC consecutive clock cycles. A condition that is held longer produces only one detection.
- R3: If the condition of R2 holds for fewer than FILT_CYC consecutive cycles, the filter count restarts from zero. While hs_on_i[i] is 0, cur_sc_i[i] produces no detection however long it stays high.
- R4: A 0-to-1 change of the synchronized cur_lim_i[i] while ls_on_i[i] is 1 opens a blanking window. lim_en_o[i] goes low on the third clock edge after the input changes and stays low for exactly BLANK_CYC cycles.
- R5: If the synchronized cur_sc_i[i] is high while the window of output i is open and ls_on_i[i] is 1, a short to supply is detected on output i. The window closes on that same edge.
- R6: A window that runs out without reaching the short threshold produces no fault. A short flag that rises after the window has closed produces no fault either.
- R7: The first detection opens a coincidence window of COIN_CYC+1 cycles. When it closes, the block gives one report. If both a high-side and a low-side detection occurred in the window, only scol_ev_o pulses. Otherwise scg_ev_o and scb_ev_o pulse together, with bit i set for each output i that was detected.
- R8: A 0-to-1 change of the synchronized ot_i produces exactly one ot_ev_o pulse, however long ot_i stays high.
- R9: shutdown_o becomes 1 after any detection or over-temperature onset. It stays 1 until a cycle in which clr_i is 1 and no new cause is present. If a cause and clr_i arrive in the same cycle, the cause wins.
- R10: Every event output pulses for one cycle per report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_on_i | input | 2 | High-side gate-on state per output (synchronous) |
| ls_on_i | input | 2 | Low-side gate-on state per output (synchronous) |
| cur_lim_i | input | 2 | Current above regulation limit, per output (asynchronous) |
| cur_sc_i | input | 2 | Current above short threshold, per output (asynchronous) |
| ot_i | input | 1 | Over-temperature flag (asynchronous) |
| clr_i | input | 1 | Clear of the shutdown request |
| shutdown_o | output | 1 | Request to turn every output transistor off |
| lim_en_o | output | 2 | Chopper current-limit enable per output, low while blanking |
| scg_ev_o | output | 2 | Short-to-ground event pulse per output |
| scb_ev_o | output | 2 | Short-to-supply event pulse per output |
| scol_ev_o | output | 1 | Short-across-load event pulse |
| ot_ev_o | output | 1 | Over-temperature event pulse |

## Verification
A filter count that failed to restart after a drop in the condition would show up as an event pulse and a raised shutdown_o after a glitch one cycle shorter than the filter. That pulse would appear within COIN_CYC+1 cycles of the glitch ending. A blanking counter that was off by one would move the fall or the return of lim_en_o by a single cycle, so the bench samples those edges exactly. A classifier whose pending state was wrong would report a separate scg_ev_o or scb_ev_o pulse in place of scol_ev_o, or the reverse, when the window closes. The scoreboard catches that as a mismatched item.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  // Number of bridge outputs watched by the detector
  localparam int unsigned BFD_NOUT = 2;

  typedef enum logic {
    CLS_IDLE,
    CLS_OPEN
  } cls_state_t;

  // Width of the synchronized comparator bus: limit, short, over-temperature
  localparam int unsigned BFD_SYNC_W = 2 * BFD_NOUT + 1;
endpackage

// File: rtl/bfd_sync.sv
module bfd_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      sync_o  <= '0;
    end else begin
      stage_q <= async_i;
      sync_o  <= stage_q;
    end
  end
endmodule

// File: rtl/bfd_hs_filter.sv
// Short-to-ground qualifier for one output: consecutive-cycle filter.
module bfd_hs_filter #(
  parameter int unsigned FILT_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_on_i,
  input  logic sc_i,
  output logic det_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          cond;
  logic [CW-1:0] cnt_q;

  assign cond = hs_on_i & sc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      det_o <= 1'b0;
    end else begin
      det_o <= cond && (cnt_q == LAST);
      if (!cond) begin
        cnt_q <= '0;
      end else if (cnt_q != FULL) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bfd_ls_blank.sv
// Low-side blanking window and short-to-supply qualifier for one output.
module bfd_ls_blank #(
  parameter int unsigned BLANK_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ls_on_i,
  input  logic lim_i,
  input  logic sc_i,
  output logic lim_en_o,
  output logic det_o
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

  logic          lim_prev_q;
  logic [CW-1:0] win_q;
  logic          active;
  logic          crossing;
  logic          hit;

  assign active   = (win_q != '0);
  assign crossing = ls_on_i & lim_i & ~lim_prev_q;
  assign hit      = active & ls_on_i & sc_i;
  assign lim_en_o = ~active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_prev_q <= 1'b0;
      win_q      <= '0;
      det_o      <= 1'b0;
    end else begin
      lim_prev_q <= lim_i;
      det_o      <= hit;
      if (hit) begin
        win_q <= '0;
      end else if (crossing) begin
        win_q <= LOAD;
      end else if (active) begin
        win_q <= win_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bfd_classifier.sv
// Gathers detections over a coincidence window and issues one report.
module bfd_classifier
  import bfd_pkg::*;
#(
  parameter int unsigned COIN_CYC = 200
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BFD_NOUT-1:0] hs_det_i,
  input  logic [BFD_NOUT-1:0] ls_det_i,
  output logic [BFD_NOUT-1:0] scg_ev_o,
  output logic [BFD_NOUT-1:0] scb_ev_o,
  output logic                scol_ev_o
);
  localparam int unsigned CW = $clog2(COIN_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(COIN_CYC - 1);

  cls_state_t          state_q;
  logic [CW-1:0]       cnt_q;
  logic [BFD_NOUT-1:0] hs_pend_q, ls_pend_q;
  logic [BFD_NOUT-1:0] hs_next, ls_next;

  always_comb begin
    hs_next = hs_pend_q | hs_det_i;
    ls_next = ls_pend_q | ls_det_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CLS_IDLE;
      cnt_q     <= '0;
      hs_pend_q <= '0;
      ls_pend_q <= '0;
      scg_ev_o  <= '0;
      scb_ev_o  <= '0;
      scol_ev_o <= 1'b0;
    end else begin
      scg_ev_o  <= '0;
      scb_ev_o  <= '0;
      scol_ev_o <= 1'b0;
      unique case (state_q)
        CLS_IDLE: begin
          if ((|hs_det_i) || (|ls_det_i)) begin
            state_q   <= CLS_OPEN;
            cnt_q     <= LOAD;
            hs_pend_q <= hs_det_i;
            ls_pend_q <= ls_det_i;
          end
        end
        CLS_OPEN: begin
          if (cnt_q == '0) begin
            state_q   <= CLS_IDLE;
            hs_pend_q <= '0;
            ls_pend_q <= '0;
            if ((|hs_next) && (|ls_next)) begin
              scol_ev_o <= 1'b1;
            end else begin
              scg_ev_o <= hs_next;
              scb_ev_o <= ls_next;
            end
          end else begin
            cnt_q     <= cnt_q - 1'b1;
            hs_pend_q <= hs_next;
            ls_pend_q <= ls_next;
          end
        end
        default: state_q <= CLS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_fault_detector.sv
module bridge_fault_detector
  import bfd_pkg::*;
#(
  parameter int unsigned FILT_CYC  = 200,
  parameter int unsigned BLANK_CYC = 100,
  parameter int unsigned COIN_CYC  = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] hs_on_i,
  input  logic [1:0] ls_on_i,
  input  logic [1:0] cur_lim_i,
  input  logic [1:0] cur_sc_i,
  input  logic       ot_i,
  input  logic       clr_i,
  output logic       shutdown_o,
  output logic [1:0] lim_en_o,
  output logic [1:0] scg_ev_o,
  output logic [1:0] scb_ev_o,
  output logic       scol_ev_o,
  output logic       ot_ev_o
);
  logic [BFD_SYNC_W-1:0] sync_bus;
  logic [BFD_NOUT-1:0]   lim_s, sc_s;
  logic                  ot_s, ot_prev_q, ot_rise;
  logic [BFD_NOUT-1:0]   hs_det, ls_det;
  logic                  sd_set;

  bfd_sync #(.WIDTH(BFD_SYNC_W)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ot_i, cur_sc_i, cur_lim_i}),
    .sync_o  (sync_bus)
  );

  assign lim_s = sync_bus[BFD_NOUT-1:0];
  assign sc_s  = sync_bus[2*BFD_NOUT-1:BFD_NOUT];
  assign ot_s  = sync_bus[2*BFD_NOUT];

  for (genvar g = 0; g < BFD_NOUT; g++) begin : g_out
    bfd_hs_filter #(.FILT_CYC(FILT_CYC)) i_hs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hs_on_i (hs_on_i[g]),
      .sc_i    (sc_s[g]),
      .det_o   (hs_det[g])
    );
    bfd_ls_blank #(.BLANK_CYC(BLANK_CYC)) i_ls (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ls_on_i  (ls_on_i[g]),
      .lim_i    (lim_s[g]),
      .sc_i     (sc_s[g]),
      .lim_en_o (lim_en_o[g]),
      .det_o    (ls_det[g])
    );
  end

  bfd_classifier #(.COIN_CYC(COIN_CYC)) i_cls (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_det_i  (hs_det),
    .ls_det_i  (ls_det),
    .scg_ev_o  (scg_ev_o),
    .scb_ev_o  (scb_ev_o),
    .scol_ev_o (scol_ev_o)
  );

  assign ot_rise = ot_s & ~ot_prev_q;
  assign sd_set  = (|hs_det) | (|ls_det) | ot_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ot_prev_q  <= 1'b0;
      ot_ev_o    <= 1'b0;
      shutdown_o <= 1'b0;
    end else begin
      ot_prev_q <= ot_s;
      ot_ev_o   <= ot_rise;
      if (sd_set) begin
        shutdown_o <= 1'b1;
      end else if (clr_i) begin
        shutdown_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bfd_checker.sv
module bfd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       sd_set,
  input logic       shutdown_o,
  input logic [1:0] scg_ev_o,
  input logic [1:0] scb_ev_o,
  input logic       scol_ev_o,
  input logic       ot_ev_o
);
  AST_SD_ON_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_set |=> shutdown_o); // R9
  AST_SD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && !clr_i) |=> shutdown_o); // R9
  AST_SD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !sd_set) |=> !shutdown_o); // R9
  AST_SCOL_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scol_ev_o |-> (scg_ev_o == 2'b00 && scb_ev_o == 2'b00)); // R7
  AST_OT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_ev_o |=> !ot_ev_o); // R8
  AST_REPORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|scg_ev_o) || (|scb_ev_o) || scol_ev_o) |=>
      (scg_ev_o == 2'b00 && scb_ev_o == 2'b00 && !scol_ev_o)); // R10
endmodule

bind bridge_fault_detector bfd_checker i_bfd_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .sd_set     (sd_set),
  .shutdown_o (shutdown_o),
  .scg_ev_o   (scg_ev_o),
  .scb_ev_o   (scb_ev_o),
  .scol_ev_o  (scol_ev_o),
  .ot_ev_o    (ot_ev_o)
);

// File: tb/test_bridge_fault_detector.sv
module test_bridge_fault_detector;
  localparam int unsigned FILT  = 4;
  localparam int unsigned BLANK = 6;
  localparam int unsigned COIN  = 5;

  typedef struct {
    logic [5:0] ev;   // {scg[1:0], scb[1:0], scol, ot}
    string      req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] hs_on = '0, ls_on = '0, lim = '0, sc = '0;
  logic ot = 1'b0, clr = 1'b0;
  logic shutdown, scol_ev, ot_ev;
  logic [1:0] lim_en, scg_ev, scb_ev;

  int checks = 0, errors = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  bridge_fault_detector #(.FILT_CYC(FILT), .BLANK_CYC(BLANK), .COIN_CYC(COIN))
  i_bridge_fault_detector (
    .clk_i(clk), .rst_ni(rst_n), .hs_on_i(hs_on), .ls_on_i(ls_on),
    .cur_lim_i(lim), .cur_sc_i(sc), .ot_i(ot), .clr_i(clr),
    .shutdown_o(shutdown), .lim_en_o(lim_en), .scg_ev_o(scg_ev),
    .scb_ev_o(scb_ev), .scol_ev_o(scol_ev), .ot_ev_o(ot_ev)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(input logic [5:0] ev, input string req);
    exp_t e;
    e.ev = ev; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle_all();
    hs_on = '0; ls_on = '0; lim = '0; sc = '0; ot = 1'b0;
  endtask

  task automatic clear_sd(input string req);
    cyc(COIN + 8);
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk(shutdown == 1'b0, req, shutdown, 0);
  endtask

  // Monitor: pops the scoreboard whenever a report appears
  always @(negedge clk) begin
    logic [5:0] got;
    if (rst_n) begin
      got = {scg_ev, scb_ev, scol_ev, ot_ev};
      if (got != '0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 R6 R8 R10 spurious event", got, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(got == e.ev, e.req, got, e.ev);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(shutdown == 1'b0, "R1 shutdown", shutdown, 0);
    chk(lim_en == 2'b11, "R1 lim_en", lim_en, 3);
    chk({scg_ev, scb_ev, scol_ev, ot_ev} == '0, "R1 events", {scg_ev, scb_ev, scol_ev, ot_ev}, 0);

    // R2 short to ground on output 0, held long: one report
    expect_ev(6'b01_00_0_0, "R2 scg0");
    hs_on = 2'b01; sc = 2'b01;
    cyc(FILT + 12);
    chk(shutdown == 1'b1, "R9 shutdown after scg", shutdown, 1);
    idle_all();
    clear_sd("R9 clear after scg");

    // R3 glitches one cycle short of the filter, with a one-cycle gap
    hs_on = 2'b01;
    sc = 2'b01; cyc(FILT - 1); sc = 2'b00; cyc(1);
    sc = 2'b01; cyc(FILT - 1); sc = 2'b00;
    cyc(COIN + 10);
    chk(shutdown == 1'b0, "R3 glitch ignored", shutdown, 0);
    // R3 high-side off: no detection
    hs_on = 2'b00; sc = 2'b11; cyc(FILT + COIN + 10);
    chk(shutdown == 1'b0, "R3 hs off ignored", shutdown, 0);
    idle_all(); cyc(4);

    // R4 blanking window length on output 1; R6 expiry without fault
    ls_on = 2'b10; lim = 2'b10;
    cyc(2); chk(lim_en[1] == 1'b1, "R4 before window", lim_en[1], 1);
    cyc(1); chk(lim_en[1] == 1'b0, "R4 window start", lim_en[1], 0);
    cyc(BLANK - 1); chk(lim_en[1] == 1'b0, "R4 window last", lim_en[1], 0);
    cyc(1); chk(lim_en[1] == 1'b1, "R6 limit re-enabled", lim_en[1], 1);
    sc = 2'b10; cyc(COIN + 10);
    chk(shutdown == 1'b0, "R6 late short ignored", shutdown, 0);
    idle_all(); cyc(4);

    // R5 short to supply inside the window on output 1
    expect_ev(6'b00_10_0_0, "R5 scb1");
    ls_on = 2'b10; lim = 2'b10;
    cyc(2); sc = 2'b10;
    cyc(2); chk(lim_en[1] == 1'b0, "R5 window open", lim_en[1], 0);
    cyc(1); chk(lim_en[1] == 1'b1, "R5 window closed by detect", lim_en[1], 1);
    cyc(COIN + 6);
    chk(shutdown == 1'b1, "R9 shutdown after scb", shutdown, 1);
    idle_all();
    clear_sd("R9 clear after scb");

    // R7 coincident high-side and low-side detections: short across load
    expect_ev(6'b00_00_1_0, "R7 scol");
    hs_on = 2'b01; sc = 2'b01; ls_on = 2'b10; lim = 2'b10;
    cyc(2); sc = 2'b11;
    cyc(COIN + 14);
    idle_all();
    clear_sd("R9 clear after scol");

    // R7 detections far apart: separate reports
    expect_ev(6'b01_00_0_0, "R7 scg0 separate");
    expect_ev(6'b00_10_0_0, "R7 scb1 separate");
    hs_on = 2'b01; sc = 2'b01;
    cyc(FILT + COIN + 12);
    hs_on = 2'b00; sc = 2'b00; cyc(2);
    ls_on = 2'b10; lim = 2'b10; cyc(2); sc = 2'b10;
    cyc(COIN + 12);
    idle_all();
    clear_sd("R9 clear after separate");

    // R7 both outputs short to ground together: one report, both bits
    expect_ev(6'b11_00_0_0, "R7 scg both");
    hs_on = 2'b11; sc = 2'b11;
    cyc(FILT + COIN + 12);
    idle_all();
    clear_sd("R9 clear after dual scg");

    // R8 over-temperature held high: one pulse; R9 clear loses to new cause
    expect_ev(6'b00_00_0_1, "R8 ot");
    ot = 1'b1;
    cyc(2); clr = 1'b1; cyc(1); clr = 1'b0;
    cyc(1);
    chk(shutdown == 1'b1, "R9 cause wins over clear", shutdown, 1);
    cyc(20);
    chk(shutdown == 1'b1, "R9 shutdown holds", shutdown, 1);
    ot = 1'b0;
    clear_sd("R9 clear after ot");

    cyc(10);
    chk(q.size() == 0, "R10 all reports seen", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule